// File: doc/BRIEF.md
# Coprocessor Control and Status Registers

This block holds the control and status state that a host uses to supervise a small coprocessor. It decodes a simple word-addressed register bus and keeps a halt flag, a broken flag, single-step and interrupt-on-break mode flags, and eight software signal flags. Each flag changes only through a pair of request bits in one status write: a clear bit and a set bit. An interrupt request pair in the same write stores nothing here. It sends one-cycle raise or lower pulses to an external interrupt controller.

The block also contains a hardware semaphore for mutual exclusion between host and coprocessor software. A read of the semaphore is an atomic test-and-set, and a write to it releases the lock. A program counter register can be loaded only while the core is halted. The core's run enable is the inverse of the halt flag, and the core pulses a break input to mark a break event.

Top module: `cop_csr`

Register word addresses: 0 status, 1 DMA-full status, 2 reserved, 3 semaphore, 4 program counter. Read data appears on `rd_data` with `rd_valid` high in the cycle after the read request.

## Requirements
- R1: A status write with bit 0 (clear) set and bit 1 (set) clear forces halt to 0. Bit 1 set with bit 0 clear forces halt to 1. Both bits set, or neither bit set, leaves halt unchanged. The new value shows on `run` (`run` = not halt) in the cycle after the write.
- R2: Single-step uses status write bits 4 (clear) and 5 (set). Interrupt-on-break uses bits 6 (clear) and 7 (set). Software signal i (i = 0..7) uses bits 8+2i (clear) and 9+2i (set). Each of these flags follows the same rule as R1.
- R3: In a status write, bit 3 set with bit 2 clear gives a one-cycle `irq_raise` pulse in the next cycle. Bit 2 set with bit 3 clear gives a one-cycle `irq_lower` pulse. Both bits set, or neither set, gives no pulse.
- R4: A `break_evt` pulse sets the broken flag. Status write bit 24 clears it. If a break event and a clear arrive in the same cycle, the flag is set.
- R5: A status read returns halt in bit 0, broken in bit 1, single-step in bit 2, interrupt-on-break in bit 3 and signal i in bit 4+i. All other bits read 0.
- R6: A semaphore read returns the current lock value in bit 0 and leaves the lock at 1.
- R7: Any write to the semaphore address releases the lock to 0, whatever the write data.
- R8: A program counter write is accepted only while halt is 1. The stored value and its readback are the write data masked to 0xFFC.
- R9: The DMA-full address reads `dma_full` in bit 0. The reserved address and any unmapped address read 0. Writes to these addresses change no state.
- R10: After reset, halt is 1. The broken flag, all mode and signal flags, the semaphore and the program counter are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_valid | input | 1 | Register access request |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Register word address |
| bus_wdata | input | 32 | Write data |
| break_evt | input | 1 | Break event pulse from the core |
| dma_full | input | 1 | DMA queue full status |
| rd_valid | output | 1 | Read data valid, one cycle after a read |
| rd_data | output | 32 | Read data |
| irq_raise | output | 1 | Interrupt raise request pulse |
| irq_lower | output | 1 | Interrupt lower request pulse |
| run | output | 1 | Core run enable, not halt |
| pc_out | output | 12 | Program counter value to the core |

## Verification
The assertions assume that `bus_addr`, `bus_write` and `bus_wdata` are meaningful only while `bus_valid` is high, and that each cycle carries at most one access. A read and a release of the semaphore therefore never meet in the same cycle. The stimulus drives one request per cycle, changes inputs only on the falling clock edge, and mixes random write data (which often asserts both bits of a pair, or neither) with random `break_evt` pulses. Directed cases cover a break event together with a clear, a program counter write while the core runs, and back-to-back semaphore reads.

// File: rtl/cop_csr_pkg.sv
package cop_csr_pkg;
    localparam int ADDR_W = 3;

    typedef enum logic [ADDR_W-1:0] {
        REG_STATUS = 3'd0,
        REG_DMAFUL = 3'd1,
        REG_RSVD   = 3'd2,
        REG_SEMA   = 3'd3,
        REG_PC     = 3'd4
    } reg_addr_e;

    // bit positions of the interrupt request pair in a status write
    localparam int IRQ_CLR_BIT = 2;
    localparam int IRQ_SET_BIT = 3;
endpackage

// File: rtl/csr_setclr.sv
module csr_setclr (
    input  logic cur,
    input  logic set_req,
    input  logic clr_req,
    output logic nxt
);
    // exactly one request forces the value; zero or two keep it
    always_comb begin
        nxt = cur;
        if (set_req ^ clr_req) nxt = set_req;
    end
endmodule

// File: rtl/csr_sema.sv
module csr_sema (
    input  logic clk,
    input  logic rst_n,
    input  logic acquire,
    input  logic release_req,
    output logic held
);
    logic held_d, held_q;

    always_comb begin
        held_d = held_q;
        if (acquire)     held_d = 1'b1;
        if (release_req) held_d = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) held_q <= 1'b0;
        else        held_q <= held_d;
    end

    assign held = held_q;

    // R6
    acquire_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        acquire && !release_req |=> held);
    // R7
    release_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        release_req |=> !held);
endmodule

// File: rtl/cop_csr.sv
module cop_csr
    import cop_csr_pkg::*;
#(
    parameter int DATA_W  = 32,
    parameter int PC_W    = 12,
    parameter int NUM_SIG = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              break_evt,
    input  logic              dma_full,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data,
    output logic              irq_raise,
    output logic              irq_lower,
    output logic              run,
    output logic [PC_W-1:0]   pc_out
);
    // stored flags: 0 halt, 1 single-step, 2 irq-on-break, 3.. signals
    localparam int NFLAG     = 3 + NUM_SIG;
    localparam int BROKE_CLR = 2 * (NFLAG + 1);
    localparam int STAT_W    = NFLAG + 1;
    localparam logic [PC_W-1:0] PC_MASK = ~(PC_W'(3));

    typedef struct packed {
        logic [NFLAG-1:0]  flags;
        logic              broke;
        logic [PC_W-1:0]   pc;
        logic              irq_raise;
        logic              irq_lower;
        logic              rd_valid;
        logic [DATA_W-1:0] rd_data;
    } state_t;

    state_t s_d, s_q;
    logic [NFLAG-1:0]  flag_nxt;
    logic [STAT_W-1:0] stat_vec;
    logic              wr_req, rd_req, wr_status, sema_held;

    assign wr_req    = bus_valid && bus_write;
    assign rd_req    = bus_valid && !bus_write;
    assign wr_status = wr_req && (bus_addr == REG_STATUS);

    // halt uses request pair 0; pair 1 is the interrupt; others follow
    for (genvar k = 0; k < NFLAG; k++) begin : g_flag
        localparam int PAIR = (k == 0) ? 0 : k + 1;
        csr_setclr u_sc (
            .cur     (s_q.flags[k]),
            .set_req (bus_wdata[2*PAIR+1]),
            .clr_req (bus_wdata[2*PAIR]),
            .nxt     (flag_nxt[k])
        );
    end

    csr_sema u_sema (
        .clk         (clk),
        .rst_n       (rst_n),
        .acquire     (rd_req && (bus_addr == REG_SEMA)),
        .release_req (wr_req && (bus_addr == REG_SEMA)),
        .held        (sema_held)
    );

    assign stat_vec = {s_q.flags[NFLAG-1:1], s_q.broke, s_q.flags[0]};

    always_comb begin
        s_d           = s_q;
        s_d.irq_raise = 1'b0;
        s_d.irq_lower = 1'b0;
        s_d.rd_valid  = 1'b0;
        if (wr_status) begin
            s_d.flags     = flag_nxt;
            s_d.irq_raise = bus_wdata[IRQ_SET_BIT] && !bus_wdata[IRQ_CLR_BIT];
            s_d.irq_lower = bus_wdata[IRQ_CLR_BIT] && !bus_wdata[IRQ_SET_BIT];
            if (bus_wdata[BROKE_CLR]) s_d.broke = 1'b0;
        end
        if (break_evt) s_d.broke = 1'b1;
        if (wr_req && bus_addr == REG_PC && s_q.flags[0])
            s_d.pc = bus_wdata[PC_W-1:0] & PC_MASK;
        if (rd_req) begin
            s_d.rd_valid = 1'b1;
            case (bus_addr)
                REG_STATUS: s_d.rd_data = DATA_W'(stat_vec);
                REG_DMAFUL: s_d.rd_data = DATA_W'(dma_full);
                REG_SEMA:   s_d.rd_data = DATA_W'(sema_held);
                REG_PC:     s_d.rd_data = DATA_W'(s_q.pc);
                default:    s_d.rd_data = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q          <= '0;
            s_q.flags[0] <= 1'b1;
        end else begin
            s_q <= s_d;
        end
    end

    assign rd_valid  = s_q.rd_valid;
    assign rd_data   = s_q.rd_data;
    assign irq_raise = s_q.irq_raise;
    assign irq_lower = s_q.irq_lower;
    assign run       = !s_q.flags[0];
    assign pc_out    = s_q.pc;

    // R1
    halt_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_status && bus_wdata[1] && !bus_wdata[0] |=> !run);
    // R1
    halt_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_status && bus_wdata[1] && bus_wdata[0] |=> $stable(run));
    // R3
    irq_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_status && bus_wdata[IRQ_SET_BIT] && !bus_wdata[IRQ_CLR_BIT] |=> irq_raise && !irq_lower);
    // R3
    irq_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_status |=> !irq_raise && !irq_lower);
    // R4
    break_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        break_evt |=> s_q.broke);
    // R8
    pc_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        run |=> $stable(pc_out));
    // R8
    pc_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pc_out[1:0] == 2'b00);
endmodule

// File: tb/cop_csr_tb_top.sv
`timescale 1ns/1ps
module cop_csr_tb_top;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        bus_valid, bus_write, break_evt, dma_full;
    logic [2:0]  bus_addr;
    logic [31:0] bus_wdata;
    logic        rd_valid, irq_raise, irq_lower, run;
    logic [31:0] rd_data;
    logic [11:0] pc_out;

    int errors = 0;
    int checks = 0;

    // model state
    logic        m_halt, m_broke, m_sstep, m_iob, m_sema;
    logic [7:0]  m_sig;
    logic [11:0] m_pc;
    logic        m_raise, m_lower;

    always #4 clk = ~clk;

    cop_csr dut_i (
        .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .break_evt(break_evt),
        .dma_full(dma_full), .rd_valid(rd_valid), .rd_data(rd_data),
        .irq_raise(irq_raise), .irq_lower(irq_lower), .run(run), .pc_out(pc_out)
    );

    function automatic logic sc(input logic cur, input logic s, input logic c);
        if (s && !c) return 1'b1;
        if (c && !s) return 1'b0;
        return cur;
    endfunction

    function automatic logic [31:0] exp_status();
        return {20'd0, m_sig, m_iob, m_sstep, m_broke, m_halt};
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic model_reset();
        m_halt = 1; m_broke = 0; m_sstep = 0; m_iob = 0; m_sema = 0;
        m_sig = 0; m_pc = 0; m_raise = 0; m_lower = 0;
    endtask

    // one write cycle; brk drives break_evt in the same cycle
    task automatic wr(input logic [2:0] a, input logic [31:0] d, input logic brk);
        bus_valid = 1; bus_write = 1; bus_addr = a; bus_wdata = d; break_evt = brk;
        m_raise = 0; m_lower = 0;
        case (a)
            3'd0: begin
                m_halt  = sc(m_halt, d[1], d[0]);
                m_sstep = sc(m_sstep, d[5], d[4]);
                m_iob   = sc(m_iob, d[7], d[6]);
                for (int i = 0; i < 8; i++) m_sig[i] = sc(m_sig[i], d[9+2*i], d[8+2*i]);
                m_raise = d[3] && !d[2];
                m_lower = d[2] && !d[3];
                if (d[24]) m_broke = 0;
            end
            3'd3: m_sema = 0;
            3'd4: if (m_halt) m_pc = d[11:0] & 12'hFFC;
            default: ;
        endcase
        if (brk) m_broke = 1;
        @(negedge clk);
        bus_valid = 0; break_evt = 0;
        check("R3 raise", {31'd0, irq_raise}, {31'd0, m_raise});
        check("R3 lower", {31'd0, irq_lower}, {31'd0, m_lower});
        check("R1 run", {31'd0, run}, {31'd0, !m_halt});
    endtask

    task automatic rd(input logic [2:0] a, input string req);
        logic [31:0] e;
        bus_valid = 1; bus_write = 0; bus_addr = a; bus_wdata = $urandom;
        case (a)
            3'd0: e = exp_status();
            3'd1: e = {31'd0, dma_full};
            3'd3: begin e = {31'd0, m_sema}; m_sema = 1; end
            3'd4: e = {20'd0, m_pc};
            default: e = 0;
        endcase
        @(negedge clk);
        bus_valid = 0;
        check(req, {31'd0, rd_valid}, 32'd1);
        check(req, rd_data, e);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED1234));
        rst_n = 0; bus_valid = 0; bus_write = 0; bus_addr = 0; bus_wdata = 0;
        break_evt = 0; dma_full = 0;
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R10 reset state
        check("R10 run", {31'd0, run}, 32'd0);
        check("R10 pc", {20'd0, pc_out}, 32'd0);
        rd(3'd0, "R10 status");
        rd(3'd4, "R10 pc read");
        rd(3'd3, "R10 sema");                 // also R6: returns 0, takes lock
        rd(3'd3, "R6 second acquire");        // returns 1
        wr(3'd3, 32'h0, 0);                   // R7 release with zero data
        rd(3'd3, "R7 released");
        // R1 both bits / neither leave halt
        wr(3'd0, 32'h3, 0);
        wr(3'd0, 32'h0, 0);
        wr(3'd4, 32'hABF, 0);                 // R8 accepted while halted
        rd(3'd4, "R8 masked pc");
        wr(3'd0, 32'h1, 0);                   // R1 clear halt
        wr(3'd4, 32'h123, 0);                 // R8 ignored while running
        rd(3'd4, "R8 locked pc");
        // R4 break and clear together: flag stays set
        wr(3'd0, 32'h0100_0000, 1);
        rd(3'd0, "R4 break wins");
        wr(3'd0, 32'h0100_0000, 0);
        rd(3'd0, "R4 cleared");
        // R3 pulses
        wr(3'd0, 32'h8, 0);
        wr(3'd0, 32'h4, 0);
        wr(3'd0, 32'hC, 0);
        // R9 dma/reserved/unmapped, writes ignored
        dma_full = 1;
        wr(3'd1, 32'hFFFF_FFFF, 0);
        wr(3'd2, 32'hFFFF_FFFF, 0);
        rd(3'd1, "R9 dma full");
        rd(3'd2, "R9 reserved");
        rd(3'd6, "R9 unmapped");
        rd(3'd0, "R9 status untouched");
        // R2 signal and mode flags, R5 layout: set all, clear alternate
        wr(3'd0, 32'h00AA_AAA0, 0);
        rd(3'd0, "R2 R5 all set");
        wr(3'd0, 32'h0011_1110, 0);
        rd(3'd0, "R2 R5 partial clear");
        // random mix
        for (int n = 0; n < 600; n++) begin
            int op = $urandom_range(0, 9);
            dma_full = $urandom_range(0, 1);
            if (op < 4)       wr(3'd0, $urandom, ($urandom_range(0, 4) == 0));
            else if (op == 4) wr(3'd4, $urandom, 0);
            else if (op == 5) wr(3'd3, $urandom, 0);
            else if (op == 6) rd(3'd3, "R6 R7 random sema");
            else if (op == 7) rd(3'd4, "R8 random pc");
            else if (op == 8) rd(3'($urandom_range(1, 7)), "R9 random read");
            else              rd(3'd0, "R2 R4 R5 random status");
        end
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule